// File: doc/BRIEF.md
# Privileged WFI Check and Machine Trap Entry

This block is the machine-level trap unit of a 64-bit RISC-V core. For every retiring instruction the pipeline presents the instruction word and its PC. The unit looks for two encodings: wait-for-interrupt and machine-return. It decides whether each one is legal at the current privilege level. It also owns the privilege level and the trap-related machine registers: status, exception PC, cause and trap value. The trap vector base comes from outside as an input.

A wait-for-interrupt executed below machine mode while the timeout-wait bit (status bit 21) is set is illegal. So is a machine-return executed below machine mode. Either one starts an illegal-instruction exception into machine mode. The unit records the faulting PC, sets cause 2 and clears the trap value. It stacks the interrupt-enable bits, raises the privilege to machine mode and redirects fetch to the vector base. A legal machine-return restores the privilege saved in the status register and redirects to the saved exception PC. A legal wait-for-interrupt retires as a plain no-op and is reported on a pulse.

The privilege level is held in a three-state machine with states ST_USER (encoding 0), ST_SUPER (1) and ST_MACHINE (3). It has these transitions:
- TRAP_ENTRY: from ST_USER or ST_SUPER to ST_MACHINE, on an illegal instruction.
- TRAP_RETURN: from ST_MACHINE to the saved mode, on a legal machine-return.
- HOLD: the state stays where it is on any other cycle.
- RESET: forces ST_MACHINE.

All updates take effect on one rising clock edge and are visible the cycle after the instruction is presented.

Top module: `priv_trap_unit`

## Requirements
- R1: A synchronous reset puts the unit in machine mode (priv_o = 3) and clears the status, exception PC, cause and trap value registers and all pulse outputs. The redirect PC is zero.
- R2: A retiring word 0x10500073 (wait-for-interrupt) in user or supervisor mode with status bit 21 set raises trap_o for exactly one cycle after the retire edge, and wfi_done_o stays low.
- R3: On trap entry the cause register becomes 2 (interrupt bit, bit 63, clear) and the trap value register becomes 0. The exception PC becomes the PC of the faulting instruction itself, with bit 0 forced to zero.
- R4: On trap entry priv_o becomes 3, redirect_o pulses, and redirect_pc_o equals the vector base input with its two low bits cleared.
- R5: On trap entry the status field at bits 12:11 takes the previous privilege and bit 7 takes the old bit 3; bit 3 is cleared and bit 21 is unchanged.
- R6: A wait-for-interrupt that is legal (bit 21 clear, or already in machine mode) pulses wfi_done_o. It leaves the privilege and all registers unchanged and produces no trap and no redirect.
- R7: A retiring word 0x30200073 (machine-return) in machine mode redirects to the exception PC and sets the privilege to the value in status bits 12:11. It also sets bit 3 to the old bit 7, sets bit 7 to 1 and sets bits 12:11 to 0.
- R8: A machine-return in user or supervisor mode is an illegal instruction and takes the trap entry of R3, R4 and R5.
- R9: A status write keeps only bits 3, 7, 11, 12 and 21, and the other bits read as zero. Writing 2 into bits 12:11 stores 0. An exception PC write clears bit 0.
- R10: A register write (csr_wr_en_i) in the same cycle as a valid retire is dropped. A valid retire of any other encoding changes nothing.
- R11: With ret_valid_i low, the wait-for-interrupt and machine-return encodings have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_insn_i | input | 32 | Retiring instruction word |
| ret_pc_i | input | 64 | PC of the retiring instruction |
| mtvec_i | input | 64 | Trap vector base (direct mode) |
| csr_wr_en_i | input | 1 | Write one of the owned registers |
| csr_wr_sel_i | input | 1 | 0 selects status, 1 selects exception PC |
| csr_wr_data_i | input | 64 | Write data |
| priv_o | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| mstatus_o | output | 64 | Status register |
| mepc_o | output | 64 | Exception PC register |
| mcause_o | output | 64 | Cause register |
| mtval_o | output | 64 | Trap value register |
| trap_o | output | 1 | Pulse: trap entry taken |
| redirect_o | output | 1 | Pulse: fetch must restart at redirect_pc_o |
| redirect_pc_o | output | 64 | Redirect target, zero when no redirect |
| wfi_done_o | output | 1 | Pulse: legal wait-for-interrupt retired |

## Verification
The assertions assume that reset is held across at least one rising edge before use. They also assume that the pulse outputs are judged only against the retire input of the previous edge. The stimulus keeps every input change on the falling edge. It holds ret_valid_i low during reset and applies register writes only through the write port. It reaches supervisor mode only through a machine-return with bits 12:11 written to 1, so the privilege never leaves the three legal encodings that the assertions rely on.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        ST_USER    = 2'b00,
        ST_SUPER   = 2'b01,
        ST_MACHINE = 2'b11
    } mode_e;

    localparam logic [31:0] OPC_WFI  = 32'h1050_0073;
    localparam logic [31:0] OPC_MRET = 32'h3020_0073;

    localparam int unsigned ST_MIE_BIT  = 3;
    localparam int unsigned ST_MPIE_BIT = 7;
    localparam int unsigned ST_MPP_LO   = 11;
    localparam int unsigned ST_MPP_HI   = 12;
    localparam int unsigned ST_TW_BIT   = 21;

    localparam int unsigned CAUSE_ILLEGAL_INSN = 2;

endpackage

// File: rtl/trap_insn_check.sv
module trap_insn_check
    import trap_pkg::*;
#(
    parameter int ILEN = 32
) (
    input  logic            valid_i,
    input  logic [ILEN-1:0] insn_i,
    input  mode_e           mode_i,
    input  logic            tw_i,
    output logic            trap_o,
    output logic            mret_o,
    output logic            wfi_o
);

    logic is_wfi;
    logic is_mret;
    logic below_m;
    logic wfi_bad;

    always_comb begin
        is_wfi  = valid_i && (insn_i == ILEN'(OPC_WFI));
        is_mret = valid_i && (insn_i == ILEN'(OPC_MRET));
        below_m = (mode_i != ST_MACHINE);
        wfi_bad = is_wfi && below_m && tw_i;
        trap_o  = wfi_bad || (is_mret && below_m);
        mret_o  = is_mret && !below_m;
        wfi_o   = is_wfi && !wfi_bad;
    end

endmodule

// File: rtl/trap_mode_fsm.sv
module trap_mode_fsm
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_i,
    input  logic            mret_i,
    input  logic            wfi_i,
    input  logic [1:0]      mpp_i,
    input  logic [XLEN-1:0] tvec_i,
    input  logic [XLEN-1:0] epc_i,
    output mode_e           mode_o,
    output logic            trap_pulse_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            wfi_done_o
);

    mode_e state_q;
    mode_e state_d;
    mode_e ret_mode;

    always_comb begin
        unique case (mpp_i)
            2'b01:   ret_mode = ST_SUPER;
            2'b11:   ret_mode = ST_MACHINE;
            default: ret_mode = ST_USER;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_USER, ST_SUPER: begin
                if (trap_i) state_d = ST_MACHINE;
            end
            ST_MACHINE: begin
                if (mret_i) state_d = ret_mode;
            end
            default: state_d = ST_MACHINE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_MACHINE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_pulse_o  <= 1'b0;
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
            wfi_done_o    <= 1'b0;
        end else begin
            trap_pulse_o <= trap_i;
            redirect_o   <= trap_i || mret_i;
            wfi_done_o   <= wfi_i;
            if (trap_i)      redirect_pc_o <= {tvec_i[XLEN-1:2], 2'b00};
            else if (mret_i) redirect_pc_o <= epc_i;
            else             redirect_pc_o <= '0;
        end
    end

    assign mode_o = state_q;

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_i,
    input  logic            mret_i,
    input  mode_e           mode_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            wr_en_i,
    input  logic            wr_sel_i,
    input  logic [XLEN-1:0] wr_data_i,
    output logic [XLEN-1:0] mstatus_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mtval_o
);

    logic       mie_q;
    logic       mpie_q;
    logic [1:0] mpp_q;
    logic       tw_q;
    logic [1:0] wr_mpp;

    always_comb begin
        wr_mpp = wr_data_i[ST_MPP_HI:ST_MPP_LO];
        if (wr_mpp == 2'b10) wr_mpp = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mie_q  <= 1'b0;
            mpie_q <= 1'b0;
            mpp_q  <= 2'b00;
            tw_q   <= 1'b0;
        end else if (trap_i) begin
            mpp_q  <= mode_i;
            mpie_q <= mie_q;
            mie_q  <= 1'b0;
        end else if (mret_i) begin
            mie_q  <= mpie_q;
            mpie_q <= 1'b1;
            mpp_q  <= 2'b00;
        end else if (wr_en_i && !wr_sel_i) begin
            mie_q  <= wr_data_i[ST_MIE_BIT];
            mpie_q <= wr_data_i[ST_MPIE_BIT];
            mpp_q  <= wr_mpp;
            tw_q   <= wr_data_i[ST_TW_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mepc_o   <= '0;
            mcause_o <= '0;
            mtval_o  <= '0;
        end else if (trap_i) begin
            mepc_o   <= {pc_i[XLEN-1:1], 1'b0};
            mcause_o <= XLEN'(CAUSE_ILLEGAL_INSN);
            mtval_o  <= '0;
        end else if (wr_en_i && wr_sel_i) begin
            mepc_o   <= {wr_data_i[XLEN-1:1], 1'b0};
        end
    end

    always_comb begin
        mstatus_o = '0;
        mstatus_o[ST_MIE_BIT]            = mie_q;
        mstatus_o[ST_MPIE_BIT]           = mpie_q;
        mstatus_o[ST_MPP_HI:ST_MPP_LO]   = mpp_q;
        mstatus_o[ST_TW_BIT]             = tw_q;
    end

endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
    import trap_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int ILEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ret_valid_i,
    input  logic [ILEN-1:0] ret_insn_i,
    input  logic [XLEN-1:0] ret_pc_i,
    input  logic [XLEN-1:0] mtvec_i,
    input  logic            csr_wr_en_i,
    input  logic            csr_wr_sel_i,
    input  logic [XLEN-1:0] csr_wr_data_i,
    output logic [1:0]      priv_o,
    output logic [XLEN-1:0] mstatus_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mtval_o,
    output logic            trap_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            wfi_done_o
);

    mode_e mode_q;
    logic  take_trap;
    logic  take_mret;
    logic  wfi_ok;
    logic  wr_ok;

    assign wr_ok = csr_wr_en_i && !ret_valid_i;

    trap_insn_check #(.ILEN(ILEN)) u_check (
        .valid_i (ret_valid_i),
        .insn_i  (ret_insn_i),
        .mode_i  (mode_q),
        .tw_i    (mstatus_o[ST_TW_BIT]),
        .trap_o  (take_trap),
        .mret_o  (take_mret),
        .wfi_o   (wfi_ok)
    );

    trap_mode_fsm #(.XLEN(XLEN)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .trap_i        (take_trap),
        .mret_i        (take_mret),
        .wfi_i         (wfi_ok),
        .mpp_i         (mstatus_o[ST_MPP_HI:ST_MPP_LO]),
        .tvec_i        (mtvec_i),
        .epc_i         (mepc_o),
        .mode_o        (mode_q),
        .trap_pulse_o  (trap_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .wfi_done_o    (wfi_done_o)
    );

    trap_csr_bank #(.XLEN(XLEN)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .trap_i    (take_trap),
        .mret_i    (take_mret),
        .mode_i    (mode_q),
        .pc_i      (ret_pc_i),
        .wr_en_i   (wr_ok),
        .wr_sel_i  (csr_wr_sel_i),
        .wr_data_i (csr_wr_data_i),
        .mstatus_o (mstatus_o),
        .mepc_o    (mepc_o),
        .mcause_o  (mcause_o),
        .mtval_o   (mtval_o)
    );

    assign priv_o = mode_q;

endmodule

// File: rtl/priv_trap_checker.sv
module priv_trap_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            ret_valid_i,
    input logic [1:0]      priv_o,
    input logic [XLEN-1:0] mstatus_o,
    input logic [XLEN-1:0] mepc_o,
    input logic [XLEN-1:0] mcause_o,
    input logic [XLEN-1:0] mtval_o,
    input logic            trap_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic            wfi_done_o
);

    localparam logic [XLEN-1:0] KEEP_MASK =
        (XLEN'(1) << 3) | (XLEN'(1) << 7) | (XLEN'(1) << 11) |
        (XLEN'(1) << 12) | (XLEN'(1) << 21);

    assert_trap_machine_R4: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (priv_o == 2'b11) && redirect_o && (redirect_pc_o[1:0] == 2'b00));

    assert_trap_cause_R3: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (mcause_o == XLEN'(2)) && (mtval_o == '0) && !mepc_o[0]);

    assert_trap_mie_clear_R5: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> !mstatus_o[3]);

    assert_wfi_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        wfi_done_o |-> !trap_o && !redirect_o && $stable(priv_o) && $stable(mepc_o));

    assert_status_mask_R9: assert property (@(posedge clk) disable iff (rst)
        ((mstatus_o & ~KEEP_MASK) == '0) && (mstatus_o[12:11] != 2'b10));

    assert_idle_no_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(ret_valid_i) |-> !trap_o && !redirect_o && !wfi_done_o);

    assert_priv_legal_R7: assert property (@(posedge clk) disable iff (rst)
        priv_o != 2'b10);

endmodule

bind priv_trap_unit priv_trap_checker #(.XLEN(XLEN)) u_priv_trap_checker (
    .clk           (clk),
    .rst           (rst),
    .ret_valid_i   (ret_valid_i),
    .priv_o        (priv_o),
    .mstatus_o     (mstatus_o),
    .mepc_o        (mepc_o),
    .mcause_o      (mcause_o),
    .mtval_o       (mtval_o),
    .trap_o        (trap_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .wfi_done_o    (wfi_done_o)
);

// File: tb/tb_priv_trap_unit.sv
`timescale 1ns/1ps
module tb_priv_trap_unit;

    localparam logic [31:0] WFI  = 32'h1050_0073;
    localparam logic [31:0] MRET = 32'h3020_0073;
    localparam logic [31:0] NOP  = 32'h0000_0013;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ret_valid_i = 1'b0;
    logic [31:0] ret_insn_i = '0;
    logic [63:0] ret_pc_i = '0;
    logic [63:0] mtvec_i = 64'h8000_0083;
    logic        csr_wr_en_i = 1'b0;
    logic        csr_wr_sel_i = 1'b0;
    logic [63:0] csr_wr_data_i = '0;
    logic [1:0]  priv_o;
    logic [63:0] mstatus_o, mepc_o, mcause_o, mtval_o, redirect_pc_o;
    logic        trap_o, redirect_o, wfi_done_o;

    int checks = 0;
    int errors = 0;

    logic [1:0]  m_priv;
    logic [63:0] m_ms, m_mepc, m_mcause, m_mtval, m_rpc;
    logic        m_trap, m_redir, m_wfi;

    always #5 clk = ~clk;

    priv_trap_unit dut (
        .clk(clk), .rst(rst), .ret_valid_i(ret_valid_i), .ret_insn_i(ret_insn_i),
        .ret_pc_i(ret_pc_i), .mtvec_i(mtvec_i), .csr_wr_en_i(csr_wr_en_i),
        .csr_wr_sel_i(csr_wr_sel_i), .csr_wr_data_i(csr_wr_data_i),
        .priv_o(priv_o), .mstatus_o(mstatus_o), .mepc_o(mepc_o),
        .mcause_o(mcause_o), .mtval_o(mtval_o), .trap_o(trap_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .wfi_done_o(wfi_done_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R4", "priv",     64'(priv_o), 64'(m_priv));
        chk("R5", "status",   mstatus_o,   m_ms);
        chk("R3", "epc",      mepc_o,      m_mepc);
        chk("R3", "cause",    mcause_o,    m_mcause);
        chk("R3", "tval",     mtval_o,     m_mtval);
        chk("R2", "trap",     64'(trap_o), 64'(m_trap));
        chk("R4", "redirect", 64'(redirect_o), 64'(m_redir));
        chk("R4", "rpc",      redirect_pc_o, m_rpc);
        chk("R6", "wfi_done", 64'(wfi_done_o), 64'(m_wfi));
    endtask

    task automatic step(input logic v, input logic [31:0] ins, input logic [63:0] pc,
                        input logic we, input logic sel, input logic [63:0] d);
        logic below, isw, ism, tr, mr;
        logic [1:0]  n_priv;
        logic [63:0] n_ms, n_mepc, n_mcause, n_mtval, n_rpc;
        ret_valid_i = v; ret_insn_i = ins; ret_pc_i = pc;
        csr_wr_en_i = we; csr_wr_sel_i = sel; csr_wr_data_i = d;
        below = (m_priv != 2'd3);
        isw = v && (ins == WFI);
        ism = v && (ins == MRET);
        tr = (isw && below && m_ms[21]) || (ism && below);
        mr = ism && !below;
        n_priv = m_priv; n_ms = m_ms; n_mepc = m_mepc;
        n_mcause = m_mcause; n_mtval = m_mtval; n_rpc = '0;
        if (tr) begin
            n_ms[12:11] = m_priv; n_ms[7] = m_ms[3]; n_ms[3] = 1'b0;
            n_priv = 2'd3; n_mepc = pc & ~64'd1; n_mcause = 64'd2; n_mtval = '0;
            n_rpc = mtvec_i & ~64'd3;
        end else if (mr) begin
            if (m_ms[12:11] == 2'd1)      n_priv = 2'd1;
            else if (m_ms[12:11] == 2'd3) n_priv = 2'd3;
            else                          n_priv = 2'd0;
            n_ms[3] = m_ms[7]; n_ms[7] = 1'b1; n_ms[12:11] = 2'd0;
            n_rpc = m_mepc;
        end else if (we && !v) begin
            if (sel) n_mepc = d & ~64'd1;
            else begin
                n_ms = d & ((64'd1 << 3) | (64'd1 << 7) | (64'd3 << 11) | (64'd1 << 21));
                if (n_ms[12:11] == 2'd2) n_ms[12:11] = 2'd0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        m_priv = n_priv; m_ms = n_ms; m_mepc = n_mepc; m_mcause = n_mcause;
        m_mtval = n_mtval; m_rpc = n_rpc; m_trap = tr; m_redir = tr || mr;
        m_wfi = isw && !tr;
        compare_all();
    endtask

    task automatic wr(input logic sel, input logic [63:0] d);
        step(1'b0, NOP, '0, 1'b1, sel, d);
    endtask

    task automatic run(input logic [31:0] ins, input logic [63:0] pc);
        step(1'b1, ins, pc, 1'b0, 1'b0, '0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_priv = 2'd3; m_ms = '0; m_mepc = '0; m_mcause = '0; m_mtval = '0;
        m_rpc = '0; m_trap = 1'b0; m_redir = 1'b0; m_wfi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "priv reset", 64'(priv_o), 64'd3);
        chk("R1", "status reset", mstatus_o, '0);
        compare_all();

        // R6: legal WFI in machine mode, bit 21 clear
        run(WFI, 64'h8000_0010);
        chk("R6", "wfi pulse M", 64'(wfi_done_o), 64'd1);

        // set TW, MIE; write odd epc (R9 bit 0)
        wr(1'b0, (64'd1 << 21) | (64'd1 << 3));
        wr(1'b1, 64'h8000_0051);
        chk("R9", "epc bit0", mepc_o, 64'h8000_0050);

        // R6: WFI in machine mode with TW set is still legal
        run(WFI, 64'h8000_0020);
        chk("R6", "wfi M with TW", 64'(trap_o), 64'd0);

        // R7: return to user mode
        run(MRET, 64'h8000_003e);
        chk("R7", "priv after return", 64'(priv_o), 64'd0);
        chk("R7", "return target", redirect_pc_o, 64'h8000_0050);
        chk("R7", "mie from mpie", 64'(mstatus_o[3]), 64'd0);

        // R2..R5: illegal WFI in user mode
        run(NOP, 64'h8000_0050);
        run(WFI, 64'h8000_005a);
        chk("R2", "trap on user wfi", 64'(trap_o), 64'd1);
        chk("R3", "epc is wfi pc", mepc_o, 64'h8000_005a);
        chk("R3", "cause illegal", mcause_o, 64'd2);
        chk("R4", "vector", redirect_pc_o, 64'h8000_0080);
        chk("R5", "mpp user", 64'(mstatus_o[12:11]), 64'd0);

        // R11: encodings ignored without retire valid
        step(1'b0, WFI, 64'h1234, 1'b0, 1'b0, '0);
        step(1'b0, MRET, 64'h1234, 1'b0, 1'b0, '0);
        chk("R11", "no pulse idle", 64'(redirect_o), 64'd0);

        // R10: write dropped during retire
        step(1'b1, NOP, 64'h8000_0080, 1'b1, 1'b1, 64'hdead_beee);
        chk("R10", "epc kept", mepc_o, 64'h8000_005a);

        // back to user, MRET in user traps (R8)
        run(MRET, 64'h8000_0090);
        run(MRET, 64'h8000_005a);
        chk("R8", "mret in user traps", 64'(trap_o), 64'd1);
        chk("R8", "priv machine", 64'(priv_o), 64'd3);

        // R9 masking, MPP=2 becomes 0
        wr(1'b0, 64'hffff_ffff_ffff_ffff);
        chk("R9", "mask all", mstatus_o, 64'h0020_1888);
        wr(1'b0, (64'd2 << 11) | (64'd1 << 21));
        chk("R9", "mpp 2 to 0", 64'(mstatus_o[12:11]), 64'd0);

        // supervisor: MPP=1, return, WFI traps with MPP=1 (R5)
        wr(1'b0, (64'd1 << 11) | (64'd1 << 21) | (64'd1 << 7));
        wr(1'b1, 64'h8000_0100);
        run(MRET, 64'h8000_00a0);
        chk("R7", "priv super", 64'(priv_o), 64'd1);
        mtvec_i = 64'h8000_0200;
        run(WFI, 64'h8000_0104);
        chk("R5", "mpp super", 64'(mstatus_o[12:11]), 64'd1);
        chk("R5", "mpie from mie", 64'(mstatus_o[7]), 64'd1);

        // R6: TW clear, WFI in user is legal
        wr(1'b0, 64'd0);
        wr(1'b1, 64'h8000_0300);
        run(MRET, 64'h8000_0204);
        run(WFI, 64'h8000_0300);
        chk("R6", "user wfi legal", 64'(wfi_done_o), 64'd1);
        chk("R6", "user stays", 64'(priv_o), 64'd0);

        run(NOP, 64'h8000_0304);
        finish_run();
    end

endmodule